// File: doc/BRIEF.md
# Idle Power-State Controller

This block puts a small microcontroller core into an idle low-power state and brings it back out. Software requests idle by writing a self-clearing enable bit in a control register. The bit can be set by a full-register write or by a single-bit set. While idle, the block gates off instruction execution, the comparator and the brown-out detector. The oscillator, the PLL and timer 0 need no gate and keep running. A peripheral timer keeps running only when its clock comes from an independent PLL output rather than from the system clock.

A 13-bit timer 0 runs freely from reset. Each time it overflows, once every 8192 cycles, it forces an exit from idle. A multi-input wakeup request also forces an exit, without waiting for the overflow. The core runs again in the cycle after the wake event. Each exit is recorded in a sticky wake-status register, with one bit for each source. Software acknowledges the exit by a full-register write to that register.

The controller has two states. RUN is the reset state. The transition RUN→IDLE (enter) is taken on an idle request when no wake event is present in the same cycle. The transition IDLE→RUN (wake) is taken on a timer overflow or a multi-input request. In all other cycles each state holds.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset the controller is in RUN: core_run_en, comp_en, bor_en and pwm_tmr_en are 1, idle_active and tmr0_ovf are 0, and the wake-status register reads 0.
- R2: A full write (wr_kind=0) to the control register (wr_addr=0) with wr_data bit 4 set moves RUN to IDLE at the next edge. A full write with bit 4 clear leaves the state unchanged.
- R3: A bit-set write (wr_kind=1) to the control register whose index wr_data[2:0] equals 4 enters IDLE. A bit-set write with any other index does not.
- R4: Reading the control register (rd_addr=0) returns all zeros in both states, so the idle-enable bit is write-only.
- R5: While in IDLE, core_run_en, comp_en and bor_en are 0 and idle_active is 1.
- R6: tmr0_ovf pulses for one cycle every 8192 cycles. It first pulses 8191 edges after reset release. Entering or leaving idle does not disturb this timing.
- R7: A tmr0_ovf pulse during IDLE returns the controller to RUN at the next edge and sets wake-status bit 0.
- R8: A mi_wake_req during IDLE returns the controller to RUN at the next edge and sets wake-status bit 1. When both sources fire in the same cycle, both bits are set.
- R9: If an idle request coincides with a wake event (mi_wake_req or tmr0_ovf) while in RUN, idle is not entered and the wake-status register is unchanged.
- R10: The wake-status register (rd_addr=1, bits [1:0]) holds its value until an exit occurs or a full write to address 1 arrives. The full write clears it. A bit-set write to address 1 leaves it unchanged.
- R11: pwm_tmr_en is 1 in RUN. In IDLE it equals pwm_clk_sel, where 1 means the timer is clocked from the PLL output.
- R12: When a status clear and an idle exit fall in the same cycle, the exit's source bits are recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = wake-status register |
| wr_kind | input | 1 | 0 = full-register write, 1 = single-bit set |
| wr_data | input | 8 | Write data, or the bit index in [2:0] for a bit set |
| rd_addr | input | 1 | Read select, same encoding as wr_addr |
| rd_data | output | 8 | Read data |
| mi_wake_req | input | 1 | Multi-input wakeup request (already edge-qualified) |
| pwm_clk_sel | input | 1 | Peripheral timer clock source: 1 = PLL output, 0 = system clock |
| core_run_en | output | 1 | Instruction execution enable |
| comp_en | output | 1 | Comparator enable |
| bor_en | output | 1 | Brown-out detector enable |
| pwm_tmr_en | output | 1 | Peripheral timer enable |
| idle_active | output | 1 | High while in IDLE |
| tmr0_ovf | output | 1 | Timer 0 overflow pulse |

## Verification
The hardest case to reach from the ports is a timer-overflow wake. It needs the controller to sit in IDLE at the exact cycle where the free-running counter reaches its terminal count. That same cycle is also needed to test the entry-versus-wake race and the combination of a clear with both wake sources. The bench keeps its own count of edges since reset release. It waits until that count reaches 8190 and 8191, then places idle writes, clears and multi-input requests on the overflow cycle itself, across three consecutive timer periods.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_IDLE = 1'b1
    } pwr_state_t;

    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_STAT  = 1'b1;
    localparam logic WR_FULL    = 1'b0;
    localparam logic WR_BITSET  = 1'b1;

    localparam int STAT_W   = 2;
    localparam int STAT_TMR = 0;
    localparam int STAT_MIW = 1;

endpackage

// File: rtl/idle_tick_timer.sv
module idle_tick_timer #(
    parameter int TICK_W = 13
) (
    input  logic clk,
    input  logic rst_n,
    output logic ovf
);

    logic [TICK_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // terminal count: the cycle before wrap
    assign ovf = &count_q;

endmodule

// File: rtl/idle_reg_decode.sv
module idle_reg_decode #(
    parameter int DATA_W   = 8,
    parameter int IDLE_BIT = 4
) (
    input  logic              wr_valid,
    input  logic              wr_addr,
    input  logic              wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic              idle_req,
    output logic              stat_clr
);
    import idle_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic full_hit;
    logic bset_hit;

    always_comb begin
        full_hit = (wr_kind == WR_FULL) && wr_data[IDLE_BIT];
        bset_hit = (wr_kind == WR_BITSET) &&
                   (wr_data[IDX_W-1:0] == IDX_W'(IDLE_BIT));
        idle_req = wr_valid && (wr_addr == ADDR_CTRL) && (full_hit || bset_hit);
        // only the full-register form acknowledges an exit
        stat_clr = wr_valid && (wr_addr == ADDR_STAT) && (wr_kind == WR_FULL);
    end

endmodule

// File: rtl/idle_fsm.sv
module idle_fsm (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    idle_req,
    input  logic                    wake_tmr,
    input  logic                    wake_miw,
    output idle_pkg::pwr_state_t    state,
    output logic                    exit_now
);
    import idle_pkg::*;

    pwr_state_t state_q;
    pwr_state_t state_d;
    logic       wake_any;

    assign wake_any = wake_tmr || wake_miw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        exit_now = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                // wake has priority over a same-cycle entry request
                if (idle_req && !wake_any) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (wake_any) begin
                    state_d  = ST_RUN;
                    exit_now = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/idle_wake_status.sv
module idle_wake_status (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        exit_now,
    input  logic                        wake_tmr,
    input  logic                        wake_miw,
    input  logic                        stat_clr,
    output logic [idle_pkg::STAT_W-1:0] status
);
    import idle_pkg::*;

    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] src_vec;

    always_comb begin
        src_vec           = '0;
        src_vec[STAT_TMR] = wake_tmr;
        src_vec[STAT_MIW] = wake_miw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (exit_now) begin
            status_q <= src_vec;
        end else if (stat_clr) begin
            status_q <= '0;
        end
    end

    assign status = status_q;

endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl #(
    parameter int DATA_W   = 8,
    parameter int IDLE_BIT = 4,
    parameter int TICK_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_addr,
    input  logic              wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              mi_wake_req,
    input  logic              pwm_clk_sel,
    output logic              core_run_en,
    output logic              comp_en,
    output logic              bor_en,
    output logic              pwm_tmr_en,
    output logic              idle_active,
    output logic              tmr0_ovf
);
    import idle_pkg::*;

    logic                idle_req;
    logic                stat_clr;
    logic                exit_now;
    logic [STAT_W-1:0]   wake_stat;
    pwr_state_t          pwr_state;

    idle_tick_timer #(.TICK_W(TICK_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf   (tmr0_ovf)
    );

    idle_reg_decode #(.DATA_W(DATA_W), .IDLE_BIT(IDLE_BIT)) u_dec (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_kind  (wr_kind),
        .wr_data  (wr_data),
        .idle_req (idle_req),
        .stat_clr (stat_clr)
    );

    idle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_req (idle_req),
        .wake_tmr (tmr0_ovf),
        .wake_miw (mi_wake_req),
        .state    (pwr_state),
        .exit_now (exit_now)
    );

    idle_wake_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .exit_now (exit_now),
        .wake_tmr (tmr0_ovf),
        .wake_miw (mi_wake_req),
        .stat_clr (stat_clr),
        .status   (wake_stat)
    );

    // gating outputs, decoded from the state register
    always_comb begin
        core_run_en = 1'b1;
        comp_en     = 1'b1;
        bor_en      = 1'b1;
        pwm_tmr_en  = 1'b1;
        idle_active = 1'b0;
        unique case (pwr_state)
            ST_RUN: ;
            ST_IDLE: begin
                core_run_en = 1'b0;
                comp_en     = 1'b0;
                bor_en      = 1'b0;
                pwm_tmr_en  = pwm_clk_sel;
                idle_active = 1'b1;
            end
            default: ;
        endcase
    end

    // control register is write-only; status sits in the low bits
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_STAT) begin
            rd_data[STAT_W-1:0] = wake_stat;
        end
    end

endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_addr,
    input logic              wr_kind,
    input logic              rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              mi_wake_req,
    input logic              pwm_clk_sel,
    input logic              core_run_en,
    input logic              comp_en,
    input logic              bor_en,
    input logic              pwm_tmr_en,
    input logic              idle_active,
    input logic              tmr0_ovf,
    input logic [1:0]        wake_stat
);

    assert_ctrl_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 1'b0) |-> (rd_data == '0));

    assert_idle_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_active |-> (!core_run_en && !comp_en && !bor_en));

    assert_tmr_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_active && tmr0_ovf) |=> (!idle_active && wake_stat[0]));

    assert_miw_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_active && mi_wake_req) |=> (!idle_active && wake_stat[1]));

    assert_no_entry_on_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_active && (mi_wake_req || tmr0_ovf)) |=> !idle_active);

    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(idle_active && (mi_wake_req || tmr0_ovf)) &&
         !(wr_valid && wr_addr && !wr_kind)) |=> $stable(wake_stat));

    assert_pwm_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle_active |-> (pwm_tmr_en == pwm_clk_sel));

    assert_ovf_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr0_ovf |=> !tmr0_ovf);

endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_kind     (wr_kind),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .mi_wake_req (mi_wake_req),
    .pwm_clk_sel (pwm_clk_sel),
    .core_run_en (core_run_en),
    .comp_en     (comp_en),
    .bor_en      (bor_en),
    .pwm_tmr_en  (pwm_tmr_en),
    .idle_active (idle_active),
    .tmr0_ovf    (tmr0_ovf),
    .wake_stat   (wake_stat)
);

// File: tb/test_idle_pwr_ctrl.sv
`timescale 1ns/1ps
module test_idle_pwr_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_addr = 1'b0;
    logic       wr_kind = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b1;
    logic [7:0] rd_data;
    logic       mi_wake_req = 1'b0;
    logic       pwm_clk_sel = 1'b0;
    logic       core_run_en, comp_en, bor_en, pwm_tmr_en, idle_active, tmr0_ovf;

    int   n_checks = 0;
    int   n_errors = 0;
    logic finished = 1'b0;
    logic [12:0] ref_cnt = '0;

    always #10 clk = ~clk;

    idle_pwr_ctrl i_idle_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_kind(wr_kind), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mi_wake_req(mi_wake_req), .pwm_clk_sel(pwm_clk_sel),
        .core_run_en(core_run_en), .comp_en(comp_en), .bor_en(bor_en),
        .pwm_tmr_en(pwm_tmr_en), .idle_active(idle_active), .tmr0_ovf(tmr0_ovf)
    );

    // edges since reset release, modulo the timer period (R6)
    always @(posedge clk) begin
        if (!rst_n) ref_cnt <= '0;
        else        ref_cnt <= ref_cnt + 1'b1;
    end

    // vector: wv, wa, wk, wd[7:0], mi, ps, exp_idle, exp_pwm, exp_stat[1:0]
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,8'hEF,1'b0,1'b0, 1'b0,1'b1,2'b00}, // R2 bit4 clear: stay
        {1'b1,1'b0,1'b0,8'h10,1'b0,1'b0, 1'b1,1'b0,2'b00}, // R2 full write enters
        {1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,1'b0,2'b00}, // R5 hold idle, R11 sys clk
        {1'b0,1'b0,1'b0,8'h00,1'b0,1'b1, 1'b1,1'b1,2'b00}, // R11 PLL clk keeps timer
        {1'b0,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b1,2'b10}, // R8 multi-input exit
        {1'b1,1'b1,1'b1,8'h00,1'b0,1'b0, 1'b0,1'b1,2'b10}, // R10 bit-set ignored
        {1'b1,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b0,1'b1,2'b00}, // R10 full write clears
        {1'b1,1'b0,1'b1,8'h03,1'b0,1'b0, 1'b0,1'b1,2'b00}, // R3 wrong index
        {1'b1,1'b0,1'b1,8'h04,1'b0,1'b0, 1'b1,1'b0,2'b00}, // R3 bit-set enters
        {1'b0,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b1,2'b10}, // R8 exit again
        {1'b1,1'b0,1'b0,8'h10,1'b1,1'b0, 1'b0,1'b1,2'b10}, // R9 wake beats entry
        {1'b1,1'b1,1'b0,8'h55,1'b0,1'b0, 1'b0,1'b1,2'b00}  // R10 clear any data
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_outputs(input string req, input logic exp_idle);
        check(req, {7'd0, idle_active}, {7'd0, exp_idle});
        check(req, {5'd0, core_run_en, comp_en, bor_en}, exp_idle ? 8'd0 : 8'd7);
    endtask

    task automatic drive(input logic v, input logic a, input logic k, input logic [7:0] d,
                         input logic mi);
        wr_valid = v; wr_addr = a; wr_kind = k; wr_data = d; mi_wake_req = mi;
    endtask

    task automatic wait_cnt(input logic [12:0] target);
        while (ref_cnt != target) step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        idle_outputs("R1", 1'b0);
        check("R1", {7'd0, pwm_tmr_en}, 8'd1);
        check("R1", {7'd0, tmr0_ovf}, 8'd0);
        check("R1", rd_data, 8'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:6], VEC[i][5]);
            pwm_clk_sel = VEC[i][4];
            step();
            drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
            idle_outputs($sformatf("R2/R3/R5/R8/R9 vec%0d", i), VEC[i][3]);
            check($sformatf("R11 vec%0d", i), {7'd0, pwm_tmr_en}, {7'd0, VEC[i][2]});
            check($sformatf("R10 vec%0d", i), rd_data, {6'd0, VEC[i][1:0]});
        end
        pwm_clk_sel = 1'b0;

        // R4: control register reads zero while idle
        drive(1'b1, 1'b0, 1'b0, 8'hFF, 1'b0);
        step();
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        rd_addr = 1'b0;
        #1;
        check("R4", rd_data, 8'd0);
        idle_outputs("R4", 1'b1);
        rd_addr = 1'b1;

        // R6/R7: timer overflow wake at the natural boundary
        wait_cnt(13'd8190);
        check("R6", {7'd0, tmr0_ovf}, 8'd0);
        idle_outputs("R7", 1'b1);
        step();
        check("R6", {7'd0, tmr0_ovf}, 8'd1);
        idle_outputs("R7", 1'b1);
        step();
        check("R6", {7'd0, tmr0_ovf}, 8'd0);
        idle_outputs("R7", 1'b0);
        check("R7", rd_data, 8'h01);

        // clear, then R9: idle write in the overflow cycle is refused
        drive(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        step();
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        wait_cnt(13'd8191);
        check("R6", {7'd0, tmr0_ovf}, 8'd1);
        drive(1'b1, 1'b0, 1'b0, 8'h10, 1'b0);
        step();
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        idle_outputs("R9", 1'b0);
        check("R9", rd_data, 8'h00);

        // R8/R12: both sources plus a clear in one cycle
        drive(1'b1, 1'b0, 1'b1, 8'h04, 1'b0);
        step();
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        idle_outputs("R3", 1'b1);
        wait_cnt(13'd8191);
        idle_outputs("R6", 1'b1);
        drive(1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
        step();
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        idle_outputs("R12", 1'b0);
        check("R12", rd_data, 8'h03);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule